// File: doc/BRIEF.md
# Dual-Port Parallel I/Q Sample Interface

This block is the baseband-side logic for a 12-bit parallel sample link to a full-duplex radio transceiver that uses two single-ended ports, with one receive path and one transmit path. The block runs on a slot clock `clk` at twice the data-clock rate. Each `clk` cycle is one data-clock edge, called a slot. `dclk_out` is high during the slots that stand for the data-clock rising edge. In double-rate mode every slot carries a word. In single-rate mode only rising slots carry one.

On the receive side, the block registers both ports and the receive frame signal. It delays the frame to cancel the programmed data offset, then decodes the word lanes. It pairs the word taken while the frame is high with the following word, and presents one 24-bit I/Q pair with a single-cycle `rx_valid` strobe. On the transmit side, it takes one I/Q pair per frame from `tx_i`/`tx_q`, pulsing `tx_take` when it does. It then drives the two words, along with the transmit frame signal, onto the transmit lanes.

Static configuration inputs set all of the following together: capture rate, frame style, receive delay, bit order, I/Q order, port roles, lane mapping, half-word order and transmit negation. They may change only while reset is asserted.

Top module: `iq_port_if`

## Requirements
- R1: While `rst_n` is low, `rx_valid`, `align_err`, `tx_frame_out`, `pad0_out` and `pad1_out` are all 0.
- R2: With `cfg_pulse_frame`=1, the word captured with the aligned frame high is the first word of a pair and the next word, frame low, is the second; each pair raises `rx_valid` for exactly one cycle.
- R3: With `cfg_sdr`=0 every slot captures and launches; with `cfg_sdr`=1 only slots with `dclk_out` high do, so transmit pads change only at edges ending such a slot. `dclk_out` is high in slots where the slot phase (0 in the first slot after reset, toggling each slot) equals `cfg_clk_inv`.
- R4: With `cfg_pulse_frame`=0 (level frame), a frame rise starts a burst; while the frame stays high words alternate first/second; a frame low ends the burst.
- R5: No pair is output until a rising edge of the aligned receive frame has been seen after reset; a frame already high at reset release does not count.
- R6: Receive data arrives `cfg_rx_dly` (0 to 3) units after its frame; a unit is one slot when `cfg_sdr`=0 and two slots when `cfg_sdr`=1.
- R7: With `cfg_bus_rev`=1, pad bit k of each port carries logical lane bit 11-k, in both directions.
- R8: With `cfg_iq_keep`=1, the first word is I and the second is Q (receive output and transmit launch order); with 0 the two are exchanged.
- R9: With `cfg_full_port`=1, receive uses all 12 bits of port A and transmit all 12 bits of port B; port A is pad 0 unless `cfg_port_swap`=1, which makes it pad 1. Transmit pad bits not used for transmit are driven 0.
- R10: With `cfg_full_port`=0, each word is split with its upper half on port A and lower half on port B; receive uses the upper pad half and transmit the lower pad half (bits 11:6 versus 5:0), and `cfg_fd_swap`=1 exchanges these halves. Bits outside the receive lanes are ignored.
- R11: Only when `cfg_full_port`, `cfg_alt_order` and `cfg_fd_swap` are all 1, the two 6-bit halves of the port word are exchanged in both directions; otherwise `cfg_alt_order` has no effect.
- R12: With `cfg_tx_neg`=1, each transmitted word is the 12-bit two's-complement negation of its input (modulo 4096, so 0x800 stays 0x800).
- R13: `align_err` is set when a pulse-mode frame is high on two data edges in a row, or a level-mode frame falls after a first word but before its second; it then stays 1 until reset.
- R14: `tx_take` marks the launch edge where `tx_i`/`tx_q` are taken; the first word goes out with `tx_frame_out`=1, and the second goes out with `tx_frame_out`=0 in pulse mode and 1 in level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one cycle per data-clock edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sdr | input | 1 | 1: single-rate, rising slots only |
| cfg_pulse_frame | input | 1 | 1: toggling frame, 0: level frame |
| cfg_rx_dly | input | 2 | Receive data offset from frame, in units |
| cfg_bus_rev | input | 1 | Reverse pad bit order |
| cfg_iq_keep | input | 1 | 1: first word is I |
| cfg_port_swap | input | 1 | Exchange the roles of pad 0 and pad 1 |
| cfg_full_port | input | 1 | 1: whole port per direction, 0: mixed halves |
| cfg_alt_order | input | 1 | Enable half-word exchange in full-port mode |
| cfg_fd_swap | input | 1 | Exchange receive/transmit halves or word halves |
| cfg_tx_neg | input | 1 | Negate transmit samples |
| cfg_clk_inv | input | 1 | Select the opposite phase as the rising slot |
| pad0_in | input | 12 | Port 0 receive pads |
| pad1_in | input | 12 | Port 1 receive pads |
| rx_frame_in | input | 1 | Receive frame from the transceiver |
| tx_i | input | 12 | Transmit I sample |
| tx_q | input | 12 | Transmit Q sample |
| pad0_out | output | 12 | Port 0 transmit pads |
| pad1_out | output | 12 | Port 1 transmit pads |
| tx_frame_out | output | 1 | Transmit frame |
| dclk_out | output | 1 | High during rising-edge slots |
| tx_take | output | 1 | Transmit pair taken at this edge |
| rx_i | output | 12 | Received I sample |
| rx_q | output | 12 | Received Q sample |
| rx_valid | output | 1 | One-cycle strobe for a new pair |
| align_err | output | 1 | Sticky frame alignment error |

## Verification
The transmit-hold and frame-on-take properties assume that the configuration inputs stay constant while reset is released. The stimulus therefore changes the configuration only while `rst_n` is low. In single-rate mode the stimulus holds every pad and frame value for two slots, so a value is seen identically on whichever slot is the rising one. The pulse-mode stimulus drives a frame low after each second word, and a level-mode frame high for an even number of words, except where an alignment error is the intended outcome.

// File: rtl/iq_port_pkg.sv
package iq_port_pkg;
  parameter int unsigned SMP_W    = 12;
  parameter int unsigned HALF_W   = SMP_W / 2;
  parameter int unsigned RX_DLY_W = 2;

  typedef struct packed {
    logic bus_rev;
    logic port_swap;
    logic full_port;
    logic alt_order;
    logic fd_swap;
  } map_cfg_t;

  function automatic logic [SMP_W-1:0] rev_bits(input logic [SMP_W-1:0] w);
    logic [SMP_W-1:0] r;
    for (int k = 0; k < SMP_W; k++) r[k] = w[SMP_W-1-k];
    return r;
  endfunction

  function automatic logic [SMP_W-1:0] swap_halves(input logic [SMP_W-1:0] w);
    return {w[HALF_W-1:0], w[SMP_W-1:HALF_W]};
  endfunction

  function automatic logic [SMP_W-1:0] neg_word(input logic [SMP_W-1:0] w);
    return (~w) + SMP_W'(1);
  endfunction

  // Receive lane decode: pads to one logical word.
  function automatic logic [SMP_W-1:0] rx_unmap(input logic [SMP_W-1:0] p0,
                                                input logic [SMP_W-1:0] p1,
                                                input map_cfg_t c);
    logic [SMP_W-1:0] a, b, w;
    a = c.port_swap ? p1 : p0;
    b = c.port_swap ? p0 : p1;
    if (c.bus_rev) begin
      a = rev_bits(a);
      b = rev_bits(b);
    end
    if (c.full_port)
      w = (c.alt_order && c.fd_swap) ? swap_halves(a) : a;
    else if (c.fd_swap)
      w = {a[HALF_W-1:0], b[HALF_W-1:0]};
    else
      w = {a[SMP_W-1:HALF_W], b[SMP_W-1:HALF_W]};
    return w;
  endfunction

  // Transmit lane encode: one logical word to {pad0, pad1}.
  function automatic logic [2*SMP_W-1:0] tx_map(input logic [SMP_W-1:0] w,
                                                 input map_cfg_t c);
    logic [SMP_W-1:0] a, b;
    a = '0;
    b = '0;
    if (c.full_port)
      b = (c.alt_order && c.fd_swap) ? swap_halves(w) : w;
    else if (c.fd_swap) begin
      a[SMP_W-1:HALF_W] = w[SMP_W-1:HALF_W];
      b[SMP_W-1:HALF_W] = w[HALF_W-1:0];
    end else begin
      a[HALF_W-1:0] = w[SMP_W-1:HALF_W];
      b[HALF_W-1:0] = w[HALF_W-1:0];
    end
    if (c.bus_rev) begin
      a = rev_bits(a);
      b = rev_bits(b);
    end
    return c.port_swap ? {b, a} : {a, b};
  endfunction
endpackage

// File: rtl/iq_slot_timer.sv
module iq_slot_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_sdr,
  input  logic cfg_clk_inv,
  output logic rise_slot,
  output logic edge_en
);
  logic ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end

  assign rise_slot = ~(ph_q ^ cfg_clk_inv);
  assign edge_en   = ~cfg_sdr | rise_slot;
endmodule

// File: rtl/iq_rx_path.sv
module iq_rx_path
  import iq_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  map_cfg_t            mcfg,
  input  logic                cfg_sdr,
  input  logic                cfg_pulse_frame,
  input  logic                cfg_iq_keep,
  input  logic [RX_DLY_W-1:0] cfg_rx_dly,
  input  logic                edge_en,
  input  logic [SMP_W-1:0]    pad0,
  input  logic [SMP_W-1:0]    pad1,
  input  logic                frame_in,
  output logic [SMP_W-1:0]    rx_i,
  output logic [SMP_W-1:0]    rx_q,
  output logic                rx_valid,
  output logic                align_err,
  output logic                lock_o
);
  localparam int unsigned DLY_MAX = (1 << RX_DLY_W) - 1;
  localparam int unsigned HIST    = 2 * DLY_MAX;
  localparam int unsigned TAP_W   = $clog2(HIST + 1);

  logic [SMP_W-1:0] p0_r, p1_r, i_hold;
  logic             fr_r, en_r, prev_f, locked, has_i;
  logic [HIST-1:0]  fd_q;
  logic [HIST:0]    taps;
  logic [TAP_W-1:0] tap_sel;
  logic [SMP_W-1:0] word;
  logic             f, rise, lock_now, is_i, is_q, err_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p0_r <= '0;
      p1_r <= '0;
      fr_r <= 1'b0;
      en_r <= 1'b0;
      fd_q <= '0;
    end else begin
      p0_r <= pad0;
      p1_r <= pad1;
      fr_r <= frame_in;
      en_r <= edge_en;
      fd_q <= {fd_q[HIST-2:0], fr_r};
    end
  end

  // Frame is delayed to meet data that lags it by cfg_rx_dly units.
  assign taps    = {fd_q, fr_r};
  assign tap_sel = cfg_sdr ? TAP_W'({cfg_rx_dly, 1'b0}) : TAP_W'(cfg_rx_dly);
  assign f       = taps[tap_sel];
  assign word    = rx_unmap(p0_r, p1_r, mcfg);

  assign rise     = f & ~prev_f;
  assign lock_now = locked | rise;

  always_comb begin
    if (cfg_pulse_frame) begin
      is_i   = lock_now & f;
      is_q   = lock_now & ~f & has_i;
      err_ev = lock_now & f & has_i;
    end else begin
      is_i   = lock_now & f & ~has_i;
      is_q   = lock_now & f & has_i;
      err_ev = locked & ~f & has_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_f    <= 1'b1;
      locked    <= 1'b0;
      has_i     <= 1'b0;
      i_hold    <= '0;
      rx_i      <= '0;
      rx_q      <= '0;
      rx_valid  <= 1'b0;
      align_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (en_r) begin
        prev_f <= f;
        locked <= lock_now;
        if (err_ev) align_err <= 1'b1;
        if (is_i) begin
          has_i  <= 1'b1;
          i_hold <= word;
        end else if (is_q) begin
          has_i    <= 1'b0;
          rx_valid <= 1'b1;
          rx_i     <= cfg_iq_keep ? i_hold : word;
          rx_q     <= cfg_iq_keep ? word : i_hold;
        end else if (!f) begin
          has_i <= 1'b0;
        end
      end
    end
  end

  assign lock_o = locked;
endmodule

// File: rtl/iq_tx_path.sv
module iq_tx_path
  import iq_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  map_cfg_t         mcfg,
  input  logic             cfg_pulse_frame,
  input  logic             cfg_iq_keep,
  input  logic             cfg_tx_neg,
  input  logic             edge_en,
  input  logic [SMP_W-1:0] tx_i,
  input  logic [SMP_W-1:0] tx_q,
  output logic [SMP_W-1:0] pad0_o,
  output logic [SMP_W-1:0] pad1_o,
  output logic             frame_o,
  output logic             take_o
);
  logic             tx_ph;
  logic [SMP_W-1:0] hold, first_w, second_w, a_w, b_w;

  assign a_w      = cfg_iq_keep ? tx_i : tx_q;
  assign b_w      = cfg_iq_keep ? tx_q : tx_i;
  assign first_w  = cfg_tx_neg ? neg_word(a_w) : a_w;
  assign second_w = cfg_tx_neg ? neg_word(b_w) : b_w;
  assign take_o   = edge_en & ~tx_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ph   <= 1'b0;
      hold    <= '0;
      pad0_o  <= '0;
      pad1_o  <= '0;
      frame_o <= 1'b0;
    end else if (edge_en) begin
      if (!tx_ph) begin
        {pad0_o, pad1_o} <= tx_map(first_w, mcfg);
        frame_o          <= 1'b1;
        hold             <= second_w;
        tx_ph            <= 1'b1;
      end else begin
        {pad0_o, pad1_o} <= tx_map(hold, mcfg);
        frame_o          <= ~cfg_pulse_frame;
        tx_ph            <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/iq_port_if.sv
module iq_port_if
  import iq_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_sdr,
  input  logic                cfg_pulse_frame,
  input  logic [RX_DLY_W-1:0] cfg_rx_dly,
  input  logic                cfg_bus_rev,
  input  logic                cfg_iq_keep,
  input  logic                cfg_port_swap,
  input  logic                cfg_full_port,
  input  logic                cfg_alt_order,
  input  logic                cfg_fd_swap,
  input  logic                cfg_tx_neg,
  input  logic                cfg_clk_inv,
  input  logic [SMP_W-1:0]    pad0_in,
  input  logic [SMP_W-1:0]    pad1_in,
  input  logic                rx_frame_in,
  input  logic [SMP_W-1:0]    tx_i,
  input  logic [SMP_W-1:0]    tx_q,
  output logic [SMP_W-1:0]    pad0_out,
  output logic [SMP_W-1:0]    pad1_out,
  output logic                tx_frame_out,
  output logic                dclk_out,
  output logic                tx_take,
  output logic [SMP_W-1:0]    rx_i,
  output logic [SMP_W-1:0]    rx_q,
  output logic                rx_valid,
  output logic                align_err
);
  map_cfg_t mcfg;
  logic     rise_slot, launch_w, lock_w;

  assign mcfg = '{bus_rev:   cfg_bus_rev,
                  port_swap: cfg_port_swap,
                  full_port: cfg_full_port,
                  alt_order: cfg_alt_order,
                  fd_swap:   cfg_fd_swap};

  iq_slot_timer timer_i (
    .clk(clk), .rst_n(rst_n), .cfg_sdr(cfg_sdr), .cfg_clk_inv(cfg_clk_inv),
    .rise_slot(rise_slot), .edge_en(launch_w)
  );

  iq_rx_path rx_i_u (
    .clk(clk), .rst_n(rst_n), .mcfg(mcfg), .cfg_sdr(cfg_sdr),
    .cfg_pulse_frame(cfg_pulse_frame), .cfg_iq_keep(cfg_iq_keep),
    .cfg_rx_dly(cfg_rx_dly), .edge_en(launch_w), .pad0(pad0_in),
    .pad1(pad1_in), .frame_in(rx_frame_in), .rx_i(rx_i), .rx_q(rx_q),
    .rx_valid(rx_valid), .align_err(align_err), .lock_o(lock_w)
  );

  iq_tx_path tx_u (
    .clk(clk), .rst_n(rst_n), .mcfg(mcfg), .cfg_pulse_frame(cfg_pulse_frame),
    .cfg_iq_keep(cfg_iq_keep), .cfg_tx_neg(cfg_tx_neg), .edge_en(launch_w),
    .tx_i(tx_i), .tx_q(tx_q), .pad0_o(pad0_out), .pad1_o(pad1_out),
    .frame_o(tx_frame_out), .take_o(tx_take)
  );

  assign dclk_out = rise_slot;
endmodule

// File: rtl/iq_port_if_chk.sv
module iq_port_if_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_sdr,
  input logic        rx_valid,
  input logic        align_err,
  input logic        lock_w,
  input logic        launch_w,
  input logic        tx_take,
  input logic        tx_frame_out,
  input logic [11:0] pad0_out,
  input logic [11:0] pad1_out
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> align_err);

  p_no_pair_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_w |-> !rx_valid);

  p_take_frame_r14: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> tx_frame_out);

  p_sdr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cfg_sdr && !$past(launch_w)) |->
      ($stable(pad0_out) && $stable(pad1_out) && $stable(tx_frame_out)));
endmodule

bind iq_port_if iq_port_if_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_sdr(cfg_sdr), .rx_valid(rx_valid),
  .align_err(align_err), .lock_w(lock_w), .launch_w(launch_w),
  .tx_take(tx_take), .tx_frame_out(tx_frame_out),
  .pad0_out(pad0_out), .pad1_out(pad1_out)
);

// File: tb/iq_port_if_tb_top.sv
module iq_port_if_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        c_sdr, c_pulse, c_rev, c_keep, c_ps, c_full, c_alt, c_fds, c_neg, c_ci;
  logic [1:0]  c_dly;
  logic [11:0] pad0_in, pad1_in, tx_i, tx_q;
  logic        rx_frame_in;
  logic [11:0] pad0_out, pad1_out, rx_i, rx_q;
  logic        tx_frame_out, dclk_out, tx_take, rx_valid, align_err;

  iq_port_if dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sdr(c_sdr), .cfg_pulse_frame(c_pulse),
    .cfg_rx_dly(c_dly), .cfg_bus_rev(c_rev), .cfg_iq_keep(c_keep),
    .cfg_port_swap(c_ps), .cfg_full_port(c_full), .cfg_alt_order(c_alt),
    .cfg_fd_swap(c_fds), .cfg_tx_neg(c_neg), .cfg_clk_inv(c_ci),
    .pad0_in(pad0_in), .pad1_in(pad1_in), .rx_frame_in(rx_frame_in),
    .tx_i(tx_i), .tx_q(tx_q), .pad0_out(pad0_out), .pad1_out(pad1_out),
    .tx_frame_out(tx_frame_out), .dclk_out(dclk_out), .tx_take(tx_take),
    .rx_i(rx_i), .rx_q(rx_q), .rx_valid(rx_valid), .align_err(align_err)
  );

  int    n_chk = 0, n_bad = 0;
  string cur_tag = "";

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // vector: [35]sdr [34]pulse [33:32]dly [31]rev [30]keep [29]pswap
  //         [28]full [27]alt [26]fdswap [25]neg [24]clkinv [23:12]I [11:0]Q
  function automatic logic [35:0] mk(bit s, bit p, int d, bit r, bit k, bit ps,
                                     bit fu, bit al, bit fs, bit ng, bit ci,
                                     logic [11:0] i, logic [11:0] q);
    return {s, p, 2'(d), r, k, ps, fu, al, fs, ng, ci, i, q};
  endfunction

  localparam int NV = 10;
  localparam logic [35:0] VEC [NV] = '{
    mk(0,1,0,0,1,0,1,0,0,0,0, 12'h123, 12'hABC),
    mk(0,1,0,0,0,0,1,0,0,0,0, 12'h456, 12'h789),
    mk(0,1,3,1,1,0,1,0,0,0,0, 12'h801, 12'h00F),
    mk(1,1,2,0,1,1,1,0,0,0,0, 12'h3C5, 12'hA5A),
    mk(0,0,1,0,1,0,1,0,0,0,0, 12'h7FF, 12'h001),
    mk(0,1,0,0,1,0,0,0,0,0,0, 12'hE1D, 12'h2B4),
    mk(0,1,2,1,0,1,0,0,1,1,0, 12'h0F0, 12'hF0F),
    mk(0,1,0,0,1,0,1,1,1,1,0, 12'hABC, 12'h123),
    mk(1,0,1,0,1,0,1,1,0,0,1, 12'h5A3, 12'hC3C),
    mk(0,1,1,0,1,1,0,1,0,1,0, 12'h800, 12'h000)
  };

  // Which logical word bit sits on pad bit k of a port (-1: not a lane).
  function automatic int lane_bit(input bit is_tx, input int port, input int k);
    int  kk, a_port;
    bit  upper;
    kk     = c_rev ? 11 - k : k;
    a_port = c_ps ? 1 : 0;
    if (c_full) begin
      if ((port == a_port) == is_tx) return -1;
      return (c_alt && c_fds) ? (kk + 6) % 12 : kk;
    end
    upper = (!is_tx) ^ c_fds;
    if ((kk >= 6) != upper) return -1;
    return (port == a_port) ? (kk % 6) + 6 : kk % 6;
  endfunction

  function automatic logic [11:0] pad_of(input bit is_tx, input int port,
                                         input logic [11:0] w, input logic fill);
    logic [11:0] p;
    for (int k = 0; k < 12; k++) begin
      int idx;
      idx  = lane_bit(is_tx, port, k);
      p[k] = (idx < 0) ? fill : w[idx];
    end
    return p;
  endfunction

  function automatic logic [11:0] negm(input logic [11:0] x);
    return 12'(4096 - int'(x));
  endfunction

  // Expected receive pairs and stimulus units.
  logic [11:0] q_i [64];
  logic [11:0] q_q [64];
  int          q_wr = 0, q_rd = 0, valid_seen = 0;
  logic        fr_u [48];
  logic [11:0] w_u  [48];
  int          n_u = 0;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && rx_valid === 1'b1) begin
      valid_seen++;
      if (q_rd < q_wr) begin
        check({rx_i, rx_q} === {q_i[q_rd], q_q[q_rd]}, cur_tag,
              {8'h0, rx_i, rx_q}, {8'h0, q_i[q_rd], q_q[q_rd]});
        q_rd++;
      end else begin
        check(1'b0, {cur_tag, " unexpected pair (R5)"}, {8'h0, rx_i, rx_q}, 32'h0);
      end
    end
  end

  task automatic push_pair(input logic [11:0] w1, input logic [11:0] w2);
    q_i[q_wr] = c_keep ? w1 : w2;
    q_q[q_wr] = c_keep ? w2 : w1;
    q_wr++;
  endtask

  task automatic add_unit(input logic f, input logic [11:0] w);
    fr_u[n_u] = f;
    w_u[n_u]  = w;
    n_u++;
  endtask

  task automatic set_cfg(input logic [35:0] v);
    {c_sdr, c_pulse, c_dly, c_rev, c_keep, c_ps, c_full, c_alt, c_fds, c_neg, c_ci} = v[35:24];
  endtask

  task automatic do_reset(input logic fr_at_reset);
    rst_n       = 1'b0;
    pad0_in     = '0;
    pad1_in     = '0;
    rx_frame_in = fr_at_reset;
    repeat (3) @(negedge clk);
    q_wr = 0; q_rd = 0; valid_seen = 0; n_u = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive_units();
    for (int u = 0; u < n_u; u++) begin
      logic [11:0] wd;
      wd          = (u >= int'(c_dly)) ? w_u[u - int'(c_dly)] : 12'h5A5;
      pad0_in     = pad_of(1'b0, 0, wd, 1'b1);
      pad1_in     = pad_of(1'b0, 1, wd, 1'b1);
      rx_frame_in = fr_u[u];
      repeat (c_sdr ? 2 : 1) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check(q_rd == q_wr, {cur_tag, " all pairs delivered"}, q_rd, q_wr);
  endtask

  task automatic tx_check(input logic [11:0] ti, input logic [11:0] tq);
    logic [11:0] w1, w2;
    int          guard = 0;
    w1 = c_keep ? ti : tq;
    w2 = c_keep ? tq : ti;
    if (c_neg) begin w1 = negm(w1); w2 = negm(w2); end
    while (tx_take !== 1'b1 && guard < 8) begin @(negedge clk); guard++; end
    check(tx_take === 1'b1, "R14 tx_take seen", {31'h0, tx_take}, 1);
    @(negedge clk);
    check({pad0_out, pad1_out, tx_frame_out} ===
          {pad_of(1'b1, 0, w1, 1'b0), pad_of(1'b1, 1, w1, 1'b0), 1'b1},
          {cur_tag, " R14 tx first"}, {7'h0, pad0_out, pad1_out, tx_frame_out},
          {7'h0, pad_of(1'b1, 0, w1, 1'b0), pad_of(1'b1, 1, w1, 1'b0), 1'b1});
    if (c_sdr) begin
      @(negedge clk);
      check({pad0_out, pad1_out} === {pad_of(1'b1, 0, w1, 1'b0), pad_of(1'b1, 1, w1, 1'b0)},
            "R3 tx held over non-rising slot", {8'h0, pad0_out, pad1_out},
            {8'h0, pad_of(1'b1, 0, w1, 1'b0), pad_of(1'b1, 1, w1, 1'b0)});
    end
    @(negedge clk);
    check({pad0_out, pad1_out, tx_frame_out} ===
          {pad_of(1'b1, 0, w2, 1'b0), pad_of(1'b1, 1, w2, 1'b0), ~c_pulse},
          {cur_tag, " R14 tx second"}, {7'h0, pad0_out, pad1_out, tx_frame_out},
          {7'h0, pad_of(1'b1, 0, w2, 1'b0), pad_of(1'b1, 1, w2, 1'b0), ~c_pulse});
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (R1..)");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    tx_i = '0; tx_q = '0;
    set_cfg(VEC[0]);

    // Table walk: R2 R3 R4 R6 R7 R8 R9 R10 R11 R12 in varied combinations.
    for (int v = 0; v < NV; v++) begin
      logic [11:0] vi, vq;
      vi = VEC[v][23:12];
      vq = VEC[v][11:0];
      set_cfg(VEC[v]);
      tx_i = vi; tx_q = vq;
      $sformat(cur_tag, "R2/R4/R6/R7/R8/R9/R10/R11 vec%0d", v);
      do_reset(1'b0);
      add_unit(1'b0, 12'h111); add_unit(1'b0, 12'h222);
      add_unit(1'b1, vi);             add_unit(c_pulse ? 1'b0 : 1'b1, vq);
      add_unit(1'b1, ~vi);            add_unit(c_pulse ? 1'b0 : 1'b1, ~vq);
      add_unit(1'b1, vi + 12'd1);     add_unit(c_pulse ? 1'b0 : 1'b1, vq + 12'd3);
      for (int t = 0; t < 5; t++) add_unit(1'b0, 12'h333);
      push_pair(vi, vq);
      push_pair(~vi, ~vq);
      push_pair(vi + 12'd1, vq + 12'd3);
      drive_units();
      check(align_err === 1'b0, "R13 no false alignment error", {31'h0, align_err}, 0);
      $sformat(cur_tag, "R12/R3 tx vec%0d", v);
      tx_check(vi, vq);
    end

    // R5: level frame high through reset release; no pair until a real rise.
    set_cfg(mk(0,0,0,0,1,0,1,0,0,0,0, 12'h0, 12'h0));
    cur_tag = "R5 lock";
    do_reset(1'b1);
    for (int t = 0; t < 8; t++) add_unit(1'b1, 12'(12'h40 + t));
    drive_units();
    check(valid_seen == 0, "R5 no pair without frame rise", valid_seen, 0);
    n_u = 0;
    add_unit(1'b0, 12'h0); add_unit(1'b1, 12'h9A1); add_unit(1'b1, 12'h1B2);
    add_unit(1'b0, 12'h0); add_unit(1'b0, 12'h0);
    push_pair(12'h9A1, 12'h1B2);
    drive_units();

    // R13 pulse mode: two highs in a row, then sticky.
    set_cfg(mk(0,1,0,0,1,0,1,0,0,0,0, 12'h0, 12'h0));
    cur_tag = "R13 pulse";
    do_reset(1'b0);
    check(rx_valid === 1'b0 && align_err === 1'b0, "R1 reset outputs",
          {30'h0, rx_valid, align_err}, 0);
    add_unit(1'b0, 12'h000); add_unit(1'b1, 12'hA01); add_unit(1'b0, 12'hB02);
    add_unit(1'b1, 12'hC03); add_unit(1'b1, 12'hD04); add_unit(1'b0, 12'hE05);
    add_unit(1'b1, 12'hF06); add_unit(1'b0, 12'h107);
    add_unit(1'b0, 12'h0);   add_unit(1'b0, 12'h0);
    push_pair(12'hA01, 12'hB02);
    push_pair(12'hD04, 12'hE05);
    push_pair(12'hF06, 12'h107);
    drive_units();
    check(align_err === 1'b1, "R13 pulse double-high sticky", {31'h0, align_err}, 1);

    // R1: reset clears everything, checked while reset is held.
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check({rx_valid, align_err, tx_frame_out} === 3'b000 &&
          pad0_out === 12'h0 && pad1_out === 12'h0, "R1 reset state",
          {5'h0, rx_valid, align_err, tx_frame_out, pad0_out, pad1_out}, 0);

    // R13 level mode: frame falls between first and second word.
    set_cfg(mk(0,0,0,0,1,0,1,0,0,0,0, 12'h0, 12'h0));
    cur_tag = "R13 level";
    do_reset(1'b0);
    add_unit(1'b0, 12'h000); add_unit(1'b1, 12'h2A2); add_unit(1'b1, 12'h3B3);
    add_unit(1'b1, 12'h4C4); add_unit(1'b0, 12'h000); add_unit(1'b0, 12'h000);
    push_pair(12'h2A2, 12'h3B3);
    drive_units();
    check(align_err === 1'b1, "R13 level early fall", {31'h0, align_err}, 1);

    finish_run();
  end
endmodule